// File: doc/BRIEF.md
# Minimum-Mode Bus Cycle Sequencer

This block turns single transfer requests into processor-style read and write cycles on a shared 16-bit address/data bus that carries a 20-bit address. The low sixteen bus lines carry the address while the latch strobe is high and carry data afterwards. The four upper address lines carry the high address nibble first and a status nibble after that. A requester presents the address, the write data, the direction, a memory-or-I/O select, a high-byte enable, a two-bit segment code and the current interrupt-enable state. It holds the request until the block reports itself free.

Each cycle walks through four bus states, one clock each. The first state puts out the address with the latch strobe. The second and third assert the read or write strobe, the transceiver direction, the buffer enable and the status nibble. Extra wait states follow while the memory or I/O side holds `ready` low. The final state releases the strobes and raises `done`. On a read, the data on `ad_in` is captured at the clock edge that closes the last strobed state.

Top module: `mmbus_sequencer`

## Requirements
- R1: While idle, `req_ready` is 1 and the bus is quiet: `ale`=0, `ad_oe`=0, `rd_n`=`wr_n`=`den_n`=`bhe_n`=1, `m_io`=0, `dt_r`=0, `done`=0. `req_ready` is 0 from T1 through T4. A request is taken only when `req_valid` and `req_ready` are both 1; with `req_valid` low the block stays idle.
- R2: In the cycle after acceptance (T1), `ale`=1, `ad_oe`=1, `ad_out` equals address bits 15..0 and `as_out` equals address bits 19..16. `ale` is high for exactly that one cycle.
- R3: From T2 through T4, `as_out` carries status. Bit 3 is driven 0, bit 2 equals the request's interrupt-enable, and bits 1..0 equal the segment code (00 extra, 01 stack, 10 code or none, 11 data).
- R4: A read holds `rd_n`=0 and `ad_oe`=0 in T2, T3 and every wait state. The block samples `ad_in` at the edge that ends the last of these states, and `rdata` shows that value while `done` is 1.
- R5: A write holds `wr_n`=0 in T2, T3 and every wait state. It drives `ad_out` with the write data and `ad_oe`=1 from T2 through T4.
- R6: `rd_n` and `wr_n` are never 0 together, and both are 1 in T1 and T4.
- R7: `m_io` equals the memory select and `bhe_n` equals the inverse of the high-byte enable, from T1 through T4.
- R8: `ready` is sampled at the end of T3 and of each wait state. Every low sample adds one wait state, so a cycle with N low samples lasts 4+N clocks.
- R9: `dt_r` is 1 for a write and 0 for a read, from T1 through T4. `den_n` is 0 only in T2, T3 and wait states. It is never 0 while `ale` is 1, and `dt_r` does not change while `den_n` is 0.
- R10: `done` is 1 for exactly one clock, in T4. The next request can be accepted in the idle cycle that follows.
- R11: A synchronous reset (`rst_n`=0 at a clock edge) abandons any cycle and returns the bus to the idle state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus state per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_hi | input | 1 | High data byte takes part |
| req_seg | input | 2 | Segment code for status |
| req_ie | input | 1 | Interrupt-enable state for status |
| done | output | 1 | Cycle complete (T4) |
| rdata | output | 16 | Captured read data |
| ad_out | output | 16 | Multiplexed address/data out |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | 16 | Data bus in |
| as_out | output | 4 | Upper address / status nibble |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m_io | output | 1 | 1 = memory, 0 = I/O |
| dt_r | output | 1 | Transceiver direction, 1 = transmit |
| den_n | output | 1 | Data buffer enable, active low |
| bhe_n | output | 1 | High byte enable, active low |
| ready | input | 1 | Low inserts wait states |

## Verification
On every clock the assertions check the ordering rules between pins. The latch strobe lasts one cycle, the buffer enable stays off during the address phase, and the direction holds steady while the buffers are enabled. The read and write strobes never overlap, the memory select holds while a strobe is active, a low `ready` keeps the sequencer in its wait state, and `done` is a single pulse. The values that reach the pins need the bench's scenarios: the address split across both pin groups, the status nibble contents, which word is captured after a stretch of waits, the exact cycle count, and recovery from a reset partway through a cycle.

// File: rtl/mmbus_pkg.sv
// Package: shared bus-state type and segment code values for the
// bus cycle sequencer. Assumes one bus state per clock.
package mmbus_pkg;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_T3   = 3'd3,
        TS_TW   = 3'd4,
        TS_T4   = 3'd5
    } tstate_e;

    localparam logic [1:0] SEG_EXTRA = 2'b00;
    localparam logic [1:0] SEG_STACK = 2'b01;
    localparam logic [1:0] SEG_CODE  = 2'b10;
    localparam logic [1:0] SEG_DATA  = 2'b11;

    // True in the states where a read or write strobe is active.
    function automatic logic in_strobe(tstate_e s);
        return (s == TS_T2) || (s == TS_T3) || (s == TS_TW);
    endfunction

    // True from T2 to T4, when the upper nibble carries status.
    function automatic logic in_status(tstate_e s);
        return (s == TS_T2) || (s == TS_T3) || (s == TS_TW) || (s == TS_T4);
    endfunction

endpackage

// File: rtl/mmbus_tstate_fsm.sv
// Module: bus state sequencer. It steps IDLE->T1->T2->T3->(TW*)->T4->IDLE,
// sampling ready at the end of T3 and each TW. It assumes the requester
// holds its request until accept is seen.
module mmbus_tstate_fsm
    import mmbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    ready,
    output tstate_e state,
    output logic    accept,
    output logic    capture,
    output logic    done
);

    tstate_e state_nx;

    // Handshake and capture strobes decoded from the current state.
    always_comb begin
        accept  = (state == TS_IDLE) && req_valid;
        capture = ((state == TS_T3) || (state == TS_TW)) && ready;
        done    = (state == TS_T4);
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            TS_IDLE: if (req_valid) state_nx = TS_T1;
            TS_T1:   state_nx = TS_T2;
            TS_T2:   state_nx = TS_T3;
            TS_T3:   state_nx = ready ? TS_T4 : TS_TW;
            TS_TW:   state_nx = ready ? TS_T4 : TS_TW;
            TS_T4:   state_nx = TS_IDLE;
            default: state_nx = TS_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TS_IDLE;
        else        state <= state_nx;
    end

    // R8: a low ready at the end of a wait state keeps the wait state.
    p_wait_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_TW && !ready) |=> (state == TS_TW));

    // R8: a high ready at the end of T3 goes straight to T4.
    p_no_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_T3 && ready) |=> (state == TS_T4));

    // R10: completion is a single-cycle pulse.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/mmbus_req_latch.sv
// Module: request and read-data holding registers. It captures the
// request fields on accept and the bus data on capture. It assumes accept
// only occurs while idle, so the fields stay constant for the whole cycle.
module mmbus_req_latch #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic              req_hi,
    input  logic [1:0]        req_seg,
    input  logic              req_ie,
    input  logic [DATA_W-1:0] ad_in,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    output logic              lat_write,
    output logic              lat_mem,
    output logic              lat_hi,
    output logic [1:0]        lat_seg,
    output logic              lat_ie,
    output logic [DATA_W-1:0] rdata
);

    // Hold the request for the duration of the bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_write <= 1'b0;
            lat_mem   <= 1'b0;
            lat_hi    <= 1'b0;
            lat_seg   <= '0;
            lat_ie    <= 1'b0;
        end else if (accept) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_write <= req_write;
            lat_mem   <= req_mem;
            lat_hi    <= req_hi;
            lat_seg   <= req_seg;
            lat_ie    <= req_ie;
        end
    end

    // Sample the bus at the edge that closes the last strobed read state.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rdata <= '0;
        else if (capture && !lat_write) rdata <= ad_in;
    end

endmodule

// File: rtl/mmbus_pin_drive.sv
// Module: pin decoder. It maps the bus state and latched request onto the
// multiplexed pins. It assumes ADDR_W - DATA_W is 4, so the upper nibble
// carries both the address high bits and the status code.
module mmbus_pin_drive
    import mmbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  tstate_e                  state,
    input  logic [ADDR_W-1:0]        lat_addr,
    input  logic [DATA_W-1:0]        lat_wdata,
    input  logic                     lat_write,
    input  logic                     lat_mem,
    input  logic                     lat_hi,
    input  logic [1:0]               lat_seg,
    input  logic                     lat_ie,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] as_out,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     m_io,
    output logic                     dt_r,
    output logic                     den_n,
    output logic                     bhe_n
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic [HI_W-1:0] status_code;
    logic            active;

    // Build the status nibble: top bit 0, then IE, then the segment code.
    always_comb begin
        status_code         = '0;
        status_code[1:0]    = lat_seg;
        status_code[HI_W-2] = lat_ie;
        status_code[HI_W-1] = 1'b0;
    end

    // Decode the bus pins from the state and the latched request.
    always_comb begin
        active = (state != TS_IDLE);
        ale    = (state == TS_T1);
        ad_out = '0;
        ad_oe  = 1'b0;
        as_out = '0;
        if (state == TS_T1) begin
            ad_out = lat_addr[DATA_W-1:0];
            ad_oe  = 1'b1;
            as_out = lat_addr[ADDR_W-1:DATA_W];
        end else if (in_status(state)) begin
            as_out = status_code;
            if (lat_write) begin
                ad_out = lat_wdata;
                ad_oe  = 1'b1;
            end
        end
        rd_n  = !(in_strobe(state) && !lat_write);
        wr_n  = !(in_strobe(state) && lat_write);
        den_n = !in_strobe(state);
        m_io  = active && lat_mem;
        dt_r  = active && lat_write;
        bhe_n = !(active && lat_hi);
    end

    // R6: the two strobes never overlap.
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R2: the latch strobe lasts a single clock.
    p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R9: the data buffers stay off during the address phase.
    p_den_quiet_ale_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> den_n);

    // R9: the direction is settled before the buffers are enabled.
    p_dtr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !den_n |-> $stable(dt_r));

    // R7: the memory select holds while a strobe is active.
    p_mio_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> $stable(m_io));

    // R2: the address phase drives the low bus lines.
    p_ale_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && rd_n && wr_n));

endmodule

// File: rtl/mmbus_sequencer.sv
// Module: top of the bus cycle sequencer. It takes one request at a time
// and plays it out as a T1..T4 cycle on the multiplexed bus, stretched
// by ready. It assumes a 20-bit address over a 16-bit data bus by default.
module mmbus_sequencer
    import mmbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_write,
    input  logic                     req_mem,
    input  logic                     req_hi,
    input  logic [1:0]               req_seg,
    input  logic                     req_ie,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] as_out,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     m_io,
    output logic                     dt_r,
    output logic                     den_n,
    output logic                     bhe_n,
    input  logic                     ready
);

    tstate_e           state;
    logic              accept;
    logic              capture;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic              lat_write;
    logic              lat_mem;
    logic              lat_hi;
    logic [1:0]        lat_seg;
    logic              lat_ie;

    // Free to accept only while idle.
    always_comb req_ready = (state == TS_IDLE);

    mmbus_tstate_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ready     (ready),
        .state     (state),
        .accept    (accept),
        .capture   (capture),
        .done      (done)
    );

    mmbus_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_write (req_write),
        .req_mem   (req_mem),
        .req_hi    (req_hi),
        .req_seg   (req_seg),
        .req_ie    (req_ie),
        .ad_in     (ad_in),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .lat_write (lat_write),
        .lat_mem   (lat_mem),
        .lat_hi    (lat_hi),
        .lat_seg   (lat_seg),
        .lat_ie    (lat_ie),
        .rdata     (rdata)
    );

    mmbus_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .lat_write (lat_write),
        .lat_mem   (lat_mem),
        .lat_hi    (lat_hi),
        .lat_seg   (lat_seg),
        .lat_ie    (lat_ie),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .as_out    (as_out),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .m_io      (m_io),
        .dt_r      (dt_r),
        .den_n     (den_n),
        .bhe_n     (bhe_n)
    );

    // R10: a completed cycle returns to idle on the next clock.
    p_done_then_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    // R1: no cycle starts when no request was offered.
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> !ale);

endmodule

// File: tb/mmbus_sequencer_bench.sv
module mmbus_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_write = 1'b0;
    logic        req_mem = 1'b0;
    logic        req_hi = 1'b0;
    logic [1:0]  req_seg = '0;
    logic        req_ie = 1'b0;
    logic        done;
    logic [15:0] rdata;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [15:0] ad_in = '0;
    logic [3:0]  as_out;
    logic        ale, rd_n, wr_n, m_io, dt_r, den_n, bhe_n;
    logic        ready = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mmbus_sequencer u_mmbus_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
        .req_mem(req_mem), .req_hi(req_hi), .req_seg(req_seg), .req_ie(req_ie),
        .done(done), .rdata(rdata), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .as_out(as_out), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .m_io(m_io), .dt_r(dt_r), .den_n(den_n), .bhe_n(bhe_n), .ready(ready)
    );

    // Vector fields: write, mem, hi, seg[2], ie, waits[4], addr[20], wdata[16], rdin[16]
    localparam int NV = 6;
    localparam logic [61:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b1, 2'b11, 1'b1, 4'd0, 20'hABCDE, 16'h0000, 16'h5A3C},
        {1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 4'd0, 20'h12345, 16'hBEEF, 16'h0000},
        {1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 4'd3, 20'h00F0F, 16'h0000, 16'hC0DE},
        {1'b1, 1'b0, 1'b1, 2'b10, 1'b1, 4'd2, 20'hF0001, 16'h1234, 16'h0000},
        {1'b0, 1'b1, 1'b0, 2'b10, 1'b1, 4'd1, 20'h80000, 16'h0000, 16'hFFFF},
        {1'b1, 1'b1, 1'b1, 2'b00, 1'b1, 4'd5, 20'h7FFFF, 16'h8001, 16'h0000}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk("R1", {tag, " req_ready"}, req_ready, 1);
        chk("R1", {tag, " ale"}, ale, 0);
        chk("R1", {tag, " ad_oe"}, ad_oe, 0);
        chk("R1", {tag, " strobes"}, {rd_n, wr_n, den_n, bhe_n}, 4'hF);
        chk("R1", {tag, " m_io/dt_r/done"}, {m_io, dt_r, done}, 0);
    endtask

    task automatic run_vec(input logic [61:0] v);
        logic        w, mem, hi, ie;
        logic [1:0]  seg;
        int          waits, len;
        logic [19:0] addr;
        logic [15:0] wd, rin;
        logic [3:0]  st;
        w = v[61]; mem = v[60]; hi = v[59]; seg = v[58:57]; ie = v[56];
        waits = int'(v[55:52]); addr = v[51:32]; wd = v[31:16]; rin = v[15:0];
        st = {1'b0, ie, seg};
        // Idle cycle: offer the request.
        @(negedge clk);
        chk_idle("pre");
        req_addr = addr; req_wdata = wd; req_write = w; req_mem = mem;
        req_hi = hi; req_seg = seg; req_ie = ie; req_valid = 1'b1;
        ready = 1'b1;
        // T1
        @(negedge clk);
        req_valid = 1'b0;
        len = 1;
        chk("R2", "T1 ale", ale, 1);
        chk("R2", "T1 ad_oe", ad_oe, 1);
        chk("R2", "T1 ad_out", ad_out, addr[15:0]);
        chk("R2", "T1 as_out", as_out, addr[19:16]);
        chk("R6", "T1 strobes idle", {rd_n, wr_n}, 2'b11);
        chk("R9", "T1 den_n", den_n, 1);
        chk("R9", "T1 dt_r", dt_r, w);
        chk("R7", "T1 m_io/bhe_n", {m_io, bhe_n}, {mem, ~hi});
        chk("R1", "T1 busy", req_ready, 0);
        // T2, T3, then waits
        for (int s = 0; s < 2 + waits; s++) begin
            @(negedge clk);
            len++;
            if (s >= 1) begin
                ready = (s == 1 + waits);
                ad_in = ready ? rin : ~rin;
            end
            chk("R3", "status", as_out, st);
            chk("R9", "den_n strobed", den_n, 0);
            chk("R9", "dt_r", dt_r, w);
            chk("R7", "m_io/bhe_n", {m_io, bhe_n}, {mem, ~hi});
            if (w) begin
                chk("R5", "wr_n", {wr_n, rd_n}, 2'b01);
                chk("R5", "wdata", {ad_oe, ad_out}, {1'b1, wd});
            end else begin
                chk("R4", "rd_n", {rd_n, wr_n}, 2'b01);
                chk("R4", "ad_oe", ad_oe, 0);
            end
            chk("R10", "no early done", done, 0);
        end
        // T4
        @(negedge clk);
        len++;
        ready = 1'b1;
        ad_in = 16'h0BAD;
        chk("R10", "T4 done", done, 1);
        chk("R8", "cycle length", len, 4 + waits);
        chk("R6", "T4 strobes", {rd_n, wr_n}, 2'b11);
        chk("R9", "T4 den_n", den_n, 1);
        chk("R3", "T4 status", as_out, st);
        chk("R7", "T4 m_io", m_io, mem);
        if (w) chk("R5", "T4 wdata", {ad_oe, ad_out}, {1'b1, wd});
        else   chk("R4", "T4 rdata", rdata, rin);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("reset");
        rst_n = 1'b1;
        // Table-driven cycles.
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);
        // R10: back-to-back acceptance right after T4.
        run_vec(VEC[1]);
        run_vec(VEC[0]);
        // R1: no request, no cycle.
        repeat (4) begin
            @(negedge clk);
            chk_idle("no request");
        end
        // R11: reset during the strobe of a read.
        @(negedge clk);
        req_write = 1'b0; req_mem = 1'b1; req_hi = 1'b1; req_addr = 20'h55555;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R11", "pre-reset rd_n", rd_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R11 mid reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R11 after reset");
        run_vec(VEC[2]);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule